// File: doc/BRIEF.md
# Codec Serial Link Input-Frame Transmitter

This block sits on the codec side of a time-multiplexed serial audio link. It builds each outgoing input frame and shifts it out one bit per bit clock on a single data line. Each frame is a 16-bit tag phase followed by twelve 20-bit data slots, 256 bits in all. The tag phase tells the controller whether the codec is ready and which slots carry fresh content. A rising edge on the frame sync input starts a frame. After that, frames repeat back to back on their own, and a new sync rise realigns them at any point.

Record samples for the left, right and microphone channels arrive with one-cycle valid strobes, as does a pending status-read response (register address and read data). Each strobe parks its data in a per-channel holding register. At the edge that starts a frame, all held content is latched into a frame buffer and the pending flags are cleared. Every value is therefore sent in exactly one frame. A slot with nothing pending is sent as zeros and has its tag bit cleared. Reserved slots are always zero.

Top module: `ac_link_tx`

## Requirements
- R1: After reset and until the first rising edge of `sync`, `sdata` is 0.
- R2: When `sync` is sampled high at a `clk` edge after being low at the previous edge, that edge drives frame bit 0 on `sdata`, and the following edges drive bits 1 to 255 in order. This also applies when the rise comes in the middle of a frame.
- R3: The tag phase uses frame bits 0 to 15. Bit 0 is the codec-ready flag latched at frame start. Bit n, for n from 1 to 12, is the valid flag of slot n. Bits 13 to 15 are 0.
- R4: Slot n (1 to 12) occupies frame bits 16+20(n-1) to 35+20(n-1). Its word is sent bit 19 first.
- R5: If a status response is pending, slot 1 carries the 7-bit address in word bits 18:12 with all other bits 0, and slot 2 carries the 16-bit read data in bits 19:4 with bits 3:0 at 0. Tag bits 1 and 2 are then set. If no response is pending, both slots are zero and both tag bits are 0.
- R6: Slot 3 (left) and slot 4 (right) carry the pending 16-bit sample in word bits 19:4 with bits 3:0 at 0, and set their tag bit. If no sample is pending, the slot is zero and the tag bit is 0.
- R7: Slot 6 carries the pending microphone sample in word bits 19:4 with bits 3:0 at 0, and sets tag bit 6. If no sample is pending, the slot is zero and tag bit 6 is 0.
- R8: Slots 5 and 7 to 12 are always zero, and so are their tag bits.
- R9: Content is latched at the frame-start edge and then consumed. A value sent in one frame is not sent again in a later frame. A strobe arriving during a frame does not alter that frame; it appears in the next one.
- R10: When bit 255 has been sent and no sync rise occurs, the next edge starts a new frame at bit 0 without any sync activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame sync; a rising edge starts or realigns a frame |
| codec_ready | input | 1 | Ready flag placed in tag bit 0 |
| rec_left | input | 16 | Left record sample |
| rec_left_vld | input | 1 | One-cycle strobe for rec_left |
| rec_right | input | 16 | Right record sample |
| rec_right_vld | input | 1 | One-cycle strobe for rec_right |
| rec_mic | input | 16 | Microphone record sample |
| rec_mic_vld | input | 1 | One-cycle strobe for rec_mic |
| stat_addr | input | 7 | Address of the register being read back |
| stat_data | input | 16 | Read data of that register |
| stat_vld | input | 1 | One-cycle strobe for the status response |
| sdata | output | 1 | Serial frame data, registered |

## Verification
The frame builder is driven with a series of per-frame stimulus sets, and every slot of every frame is captured and compared word by word.

- A set with all channels pending checks that fields are placed correctly and do not bleed into each other.
- A set with nothing pending, straight after a full one, shows that content is consumed and not repeated.
- Sets with only some channels pending, with sample values at all-ones, all-zeros, MSB-only and LSB-only, separate a correct valid mask from a slot that is merely zero.
- Stimulus for the next frame is applied while the current frame is being sent, which shows that a frame in flight is unaffected.
- After the first frame, frames run with no sync activity, and a final mid-frame sync rise shows realignment together with delivery of a sample strobed just before it.

// File: rtl/ac_link_pkg.sv
package ac_link_pkg;

    localparam int TAG_W      = 16;
    localparam int SLOT_W     = 20;
    localparam int NUM_SLOTS  = 12;
    localparam int SAMPLE_W   = 16;
    localparam int ADDR_W     = 7;
    localparam int NUM_REC    = 3;
    localparam int FRAME_BITS = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    localparam int TAG_IDX_W  = $clog2(TAG_W);
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS + 1);
    localparam int BIT_IDX_W  = $clog2(SLOT_W);

    localparam logic [TAG_IDX_W-1:0]  TAG_LAST  = TAG_IDX_W'(TAG_W - 1);
    localparam logic [SLOT_IDX_W-1:0] SLOT_LAST = SLOT_IDX_W'(NUM_SLOTS);
    localparam logic [BIT_IDX_W-1:0]  BIT_TOP   = BIT_IDX_W'(SLOT_W - 1);

    localparam logic [SLOT_IDX_W-1:0] SL_STAT_ADDR = SLOT_IDX_W'(1);
    localparam logic [SLOT_IDX_W-1:0] SL_STAT_DATA = SLOT_IDX_W'(2);

    // record channel index: 0 left, 1 right, 2 microphone
    typedef logic [NUM_REC-1:0][SAMPLE_W-1:0] rec_bus_t;

    typedef struct packed {
        logic                  ready;
        logic                  stat_v;
        logic [ADDR_W-1:0]     stat_addr;
        logic [SAMPLE_W-1:0]   stat_data;
        logic [NUM_REC-1:0]    rec_v;
        rec_bus_t              rec;
    } frame_t;

    typedef struct packed {
        logic                  in_tag;
        logic [TAG_IDX_W-1:0]  tag_idx;
        logic [SLOT_IDX_W-1:0] slot;
        logic [BIT_IDX_W-1:0]  bitn;
    } pos_t;

    localparam pos_t POS_START = '{in_tag: 1'b1, tag_idx: '0, slot: '0, bitn: '0};

    function automatic logic [SLOT_IDX_W-1:0] rec_slot(input int ch);
        case (ch)
            0:       return SLOT_IDX_W'(3);
            1:       return SLOT_IDX_W'(4);
            default: return SLOT_IDX_W'(6);
        endcase
    endfunction

    function automatic logic slot_valid(input frame_t f, input logic [SLOT_IDX_W-1:0] s);
        logic v;
        v = (s == SL_STAT_ADDR || s == SL_STAT_DATA) ? f.stat_v : 1'b0;
        for (int ch = 0; ch < NUM_REC; ch++) begin
            if (s == rec_slot(ch)) v = f.rec_v[ch];
        end
        return v;
    endfunction

    function automatic logic [SLOT_W-1:0] slot_word(input frame_t f, input logic [SLOT_IDX_W-1:0] s);
        logic [SLOT_W-1:0] w;
        w = '0;
        if (f.stat_v && s == SL_STAT_ADDR) w[SLOT_W-2 -: ADDR_W] = f.stat_addr;
        if (f.stat_v && s == SL_STAT_DATA) w[SLOT_W-1 -: SAMPLE_W] = f.stat_data;
        for (int ch = 0; ch < NUM_REC; ch++) begin
            if (f.rec_v[ch] && s == rec_slot(ch)) w[SLOT_W-1 -: SAMPLE_W] = f.rec[ch];
        end
        return w;
    endfunction

    function automatic logic tag_bit(input frame_t f, input logic [TAG_IDX_W-1:0] idx);
        logic [SLOT_IDX_W-1:0] s;
        s = SLOT_IDX_W'(idx);
        if (idx == '0) return f.ready;
        if (s <= SLOT_LAST) return slot_valid(f, s);
        return 1'b0;
    endfunction

    function automatic pos_t pos_advance(input pos_t p);
        pos_t n;
        n = p;
        if (p.in_tag) begin
            if (p.tag_idx == TAG_LAST) begin
                n.in_tag = 1'b0;
                n.slot   = SLOT_IDX_W'(1);
                n.bitn   = BIT_TOP;
            end else begin
                n.tag_idx = p.tag_idx + 1'b1;
            end
        end else if (p.bitn != '0) begin
            n.bitn = p.bitn - 1'b1;
        end else if (p.slot != SLOT_LAST) begin
            n.slot = p.slot + 1'b1;
            n.bitn = BIT_TOP;
        end else begin
            n = POS_START;
        end
        return n;
    endfunction

    function automatic logic pos_is_last(input pos_t p);
        return !p.in_tag && p.slot == SLOT_LAST && p.bitn == '0;
    endfunction

endpackage

// File: rtl/ac_mailbox.sv
module ac_mailbox #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] din,
    input  logic         take,
    output logic         pend,
    output logic [W-1:0] dout
);
    // A strobe on the take edge belongs to the following frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            dout <= '0;
        end else if (strobe) begin
            pend <= 1'b1;
            dout <= din;
        end else if (take) begin
            pend <= 1'b0;
        end
    end
endmodule

// File: rtl/ac_frame_seq.sv
module ac_frame_seq
    import ac_link_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync,
    output logic start,
    output logic emit,
    output pos_t cur
);
    logic sync_q;
    logic running;
    logic wrap_q;
    pos_t pos_q;

    assign start = (sync && !sync_q) || (running && wrap_q);
    assign emit  = start || running;
    assign cur   = start ? POS_START : pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 1'b0;
            running <= 1'b0;
            wrap_q  <= 1'b0;
            pos_q   <= POS_START;
        end else begin
            sync_q <= sync;
            if (emit) begin
                running <= 1'b1;
                pos_q   <= pos_advance(cur);
                wrap_q  <= pos_is_last(cur);
            end
        end
    end
endmodule

// File: rtl/ac_slot_mux.sv
module ac_slot_mux
    import ac_link_pkg::*;
(
    input  frame_t frame,
    input  pos_t   pos,
    output logic   bit_out
);
    logic [SLOT_W-1:0] word;

    always_comb begin
        word = slot_word(frame, pos.slot);
        if (pos.in_tag) bit_out = tag_bit(frame, pos.tag_idx);
        else            bit_out = word[pos.bitn];
    end
endmodule

// File: rtl/ac_link_tx.sv
module ac_link_tx
    import ac_link_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sync,
    input  logic                codec_ready,
    input  logic [SAMPLE_W-1:0] rec_left,
    input  logic                rec_left_vld,
    input  logic [SAMPLE_W-1:0] rec_right,
    input  logic                rec_right_vld,
    input  logic [SAMPLE_W-1:0] rec_mic,
    input  logic                rec_mic_vld,
    input  logic [ADDR_W-1:0]   stat_addr,
    input  logic [SAMPLE_W-1:0] stat_data,
    input  logic                stat_vld,
    output logic                sdata
);
    localparam int STAT_W = ADDR_W + SAMPLE_W;

    logic     start;
    logic     emit;
    pos_t     cur;
    rec_bus_t rec_in;
    rec_bus_t rec_held;
    logic [NUM_REC-1:0] rec_stb;
    logic [NUM_REC-1:0] rec_pend;
    logic [STAT_W-1:0]  stat_held;
    logic               stat_pend;
    frame_t   fresh;
    frame_t   held;
    frame_t   active;
    logic     bit_next;
    logic     sdata_q;

    assign rec_in  = {rec_mic, rec_right, rec_left};
    assign rec_stb = {rec_mic_vld, rec_right_vld, rec_left_vld};

    ac_frame_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .sync  (sync),
        .start (start),
        .emit  (emit),
        .cur   (cur)
    );

    for (genvar ch = 0; ch < NUM_REC; ch++) begin : g_rec
        ac_mailbox #(.W(SAMPLE_W)) u_box (
            .clk    (clk),
            .rst    (rst),
            .strobe (rec_stb[ch]),
            .din    (rec_in[ch]),
            .take   (start),
            .pend   (rec_pend[ch]),
            .dout   (rec_held[ch])
        );
    end

    ac_mailbox #(.W(STAT_W)) u_stat_box (
        .clk    (clk),
        .rst    (rst),
        .strobe (stat_vld),
        .din    ({stat_addr, stat_data}),
        .take   (start),
        .pend   (stat_pend),
        .dout   (stat_held)
    );

    always_comb begin
        fresh.ready     = codec_ready;
        fresh.stat_v    = stat_pend;
        fresh.stat_addr = stat_held[STAT_W-1 -: ADDR_W];
        fresh.stat_data = stat_held[SAMPLE_W-1:0];
        fresh.rec_v     = rec_pend;
        fresh.rec       = rec_held;
    end

    always_ff @(posedge clk) begin
        if (rst)        held <= '0;
        else if (start) held <= fresh;
    end

    // The start edge emits bit 0 straight from the content being latched.
    assign active = start ? fresh : held;

    ac_slot_mux u_mux (
        .frame   (active),
        .pos     (cur),
        .bit_out (bit_next)
    );

    always_ff @(posedge clk) begin
        if (rst)       sdata_q <= 1'b0;
        else if (emit) sdata_q <= bit_next;
        else           sdata_q <= 1'b0;
    end

    assign sdata = sdata_q;
endmodule

// File: rtl/ac_link_tx_chk.sv
module ac_link_tx_chk
    import ac_link_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic sync,
    input logic codec_ready,
    input logic sdata
);
    logic             sync_prev;
    logic             live_q;
    logic [CNT_W-1:0] idx_q;
    logic             rise;
    logic             pad_tag, rsv_tag, rsv_slot, low_nib, addr_pad;
    int               rel, sn, bn;

    assign rise = sync && !sync_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_prev <= 1'b0;
            live_q    <= 1'b0;
            idx_q     <= '0;
        end else begin
            sync_prev <= sync;
            if (rise) begin
                live_q <= 1'b1;
                idx_q  <= '0;
            end else if (live_q) begin
                idx_q  <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        rel      = int'(idx_q) - TAG_W;
        sn       = (rel >= 0) ? rel / SLOT_W + 1 : 0;
        bn       = (rel >= 0) ? SLOT_W - 1 - rel % SLOT_W : 0;
        pad_tag  = live_q && rel < 0 && int'(idx_q) > NUM_SLOTS;
        rsv_tag  = live_q && (idx_q == CNT_W'(5) || (idx_q >= CNT_W'(7) && idx_q <= CNT_W'(NUM_SLOTS)));
        rsv_slot = live_q && (sn == 5 || sn >= 7);
        low_nib  = live_q && (sn == 2 || sn == 3 || sn == 4 || sn == 6) && bn < 4;
        addr_pad = live_q && sn == 1 && (bn == SLOT_W - 1 || bn < SLOT_W - 1 - ADDR_W);
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!live_q && !rise) |=> !sdata);                                   // R1
    AST_SYNC_READY_BIT: assert property (@(posedge clk) disable iff (rst)
        rise |=> (sdata == $past(codec_ready)));                          // R2
    AST_TAG_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        pad_tag |-> !sdata);                                              // R3
    AST_RSV_TAG_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsv_tag |-> !sdata);                                              // R8
    AST_RSV_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsv_slot |-> !sdata);                                             // R8
    AST_SAMPLE_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        low_nib |-> !sdata);                                              // R6
    AST_ADDR_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        addr_pad |-> !sdata);                                             // R5
endmodule

bind ac_link_tx ac_link_tx_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sync        (sync),
    .codec_ready (codec_ready),
    .sdata       (sdata)
);

// File: tb/ac_link_tx_tb.sv
module ac_link_tx_tb;

    typedef struct packed {
        logic        ready;
        logic        vl;
        logic [15:0] l;
        logic        vr;
        logic [15:0] r;
        logic        vm;
        logic [15:0] m;
        logic        vs;
        logic [6:0]  sa;
        logic [15:0] sd;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 16'hA5C3, 1'b1, 16'h5A3C, 1'b1, 16'hF00F, 1'b1, 7'h26, 16'h1234},
        '{1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 7'h00, 16'h0000},
        '{1'b0, 1'b1, 16'h8001, 1'b0, 16'h0000, 1'b1, 16'h0001, 1'b0, 7'h00, 16'h0000},
        '{1'b1, 1'b0, 16'h0000, 1'b1, 16'hFFFF, 1'b0, 16'h0000, 1'b1, 7'h7F, 16'hFFFF},
        '{1'b1, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h8000, 1'b0, 7'h00, 16'h0000},
        '{1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 7'h00, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync = 1'b0;
    logic        codec_ready = 1'b0;
    logic [15:0] rec_left = '0, rec_right = '0, rec_mic = '0, stat_data = '0;
    logic [6:0]  stat_addr = '0;
    logic        rec_left_vld = 1'b0, rec_right_vld = 1'b0, rec_mic_vld = 1'b0, stat_vld = 1'b0;
    logic        sdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [255:0] cap;

    always #4 clk = ~clk;

    ac_link_tx u_dut (
        .clk(clk), .rst(rst), .sync(sync), .codec_ready(codec_ready),
        .rec_left(rec_left), .rec_left_vld(rec_left_vld),
        .rec_right(rec_right), .rec_right_vld(rec_right_vld),
        .rec_mic(rec_mic), .rec_mic_vld(rec_mic_vld),
        .stat_addr(stat_addr), .stat_data(stat_data), .stat_vld(stat_vld),
        .sdata(sdata)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic set_stim(input vec_t v);
        codec_ready   = v.ready;
        rec_left      = v.l;  rec_left_vld  = v.vl;
        rec_right     = v.r;  rec_right_vld = v.vr;
        rec_mic       = v.m;  rec_mic_vld   = v.vm;
        stat_addr     = v.sa; stat_data     = v.sd; stat_vld = v.vs;
    endtask

    task automatic clr_strobes();
        rec_left_vld = 1'b0; rec_right_vld = 1'b0; rec_mic_vld = 1'b0; stat_vld = 1'b0;
    endtask

    function automatic logic [255:0] put_slot(input logic [255:0] f, input int n, input logic [19:0] w);
        logic [255:0] r;
        r = f;
        for (int b = 0; b < 20; b++) r[16 + 20 * (n - 1) + b] = w[19 - b];
        return r;
    endfunction

    function automatic logic [19:0] get_slot(input logic [255:0] f, input int n);
        logic [19:0] w;
        for (int b = 0; b < 20; b++) w[19 - b] = f[16 + 20 * (n - 1) + b];
        return w;
    endfunction

    function automatic logic [255:0] exp_frame(input vec_t v);
        logic [255:0] e;
        e = '0;
        e[0] = v.ready;
        e[1] = v.vs;
        e[2] = v.vs;
        e[3] = v.vl;
        e[4] = v.vr;
        e[6] = v.vm;
        if (v.vs) e = put_slot(e, 1, {1'b0, v.sa, 12'h000});
        if (v.vs) e = put_slot(e, 2, {v.sd, 4'h0});
        if (v.vl) e = put_slot(e, 3, {v.l, 4'h0});
        if (v.vr) e = put_slot(e, 4, {v.r, 4'h0});
        if (v.vm) e = put_slot(e, 6, {v.m, 4'h0});
        return e;
    endfunction

    function automatic string slot_req(input int n);
        if (n <= 2) return "R5";
        if (n <= 4) return "R6";
        if (n == 6) return "R7";
        return "R8";
    endfunction

    // Captures one frame; stimulus for the next frame is applied at bit 10 (R9).
    task automatic capture(input bit has_nxt, input vec_t nxt);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            cap[k] = sdata;
            if (k == 0) sync = 1'b0;
            if (k == 10 && has_nxt) set_stim(nxt);
            if (k == 11) clr_strobes();
        end
    endtask

    task automatic check_frame(input logic [255:0] e, input string tagreq);
        chk(cap[15:0] == e[15:0], tagreq, {16'h0, cap[15:0]}, {16'h0, e[15:0]});
        for (int n = 1; n <= 12; n++) begin
            chk(get_slot(cap, n) == get_slot(e, n),
                $sformatf("%s R4 slot %0d", slot_req(n), n),
                {12'h0, get_slot(cap, n)}, {12'h0, get_slot(e, n)});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        vec_t nv;
        vec_t mid;
        logic [255:0] e;
        logic saw_one;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: idle output before any sync rise
        saw_one = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (sdata) saw_one = 1'b1;
        end
        chk(!saw_one, "R1 idle sdata before sync", {31'h0, saw_one}, 32'h0);

        @(negedge clk);
        set_stim(VECS[0]);
        @(negedge clk);
        clr_strobes();
        @(negedge clk);
        chk(sdata == 1'b0, "R1 idle sdata after strobes", {31'h0, sdata}, 32'h0);
        sync = 1'b1;

        for (int i = 0; i < NV; i++) begin
            nv = (i + 1 < NV) ? VECS[i + 1] : VECS[NV - 1];
            capture(i + 1 < NV, nv);
            e = exp_frame(VECS[i]);
            check_frame(e, i == 0 ? "R2 R3 tag" : "R3 R10 tag");
            if (i == 0)
                chk(cap[56] == VECS[0].l[15] && cap[71] == VECS[0].l[0],
                    "R4 slot 3 msb first", {30'h0, cap[56], cap[71]},
                    {30'h0, VECS[0].l[15], VECS[0].l[0]});
            if (i == 1)
                chk(cap[12:1] == 12'h000, "R9 no repeat of consumed content",
                    {20'h0, cap[12:1]}, 32'h0);
        end

        // R2: mid-frame realignment, with a left sample strobed before it
        mid = '0;
        mid.ready = 1'b1;
        mid.vl    = 1'b1;
        mid.l     = 16'h1357;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (k == 50) set_stim(mid);
            if (k == 51) clr_strobes();
        end
        sync = 1'b1;
        capture(1'b0, mid);
        e = exp_frame(mid);
        chk(cap[15:0] == e[15:0], "R2 tag after mid-frame sync", {16'h0, cap[15:0]}, {16'h0, e[15:0]});
        chk(get_slot(cap, 3) == get_slot(e, 3), "R2 slot 3 after mid-frame sync",
            {12'h0, get_slot(cap, 3)}, {12'h0, get_slot(e, 3)});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule